// File: doc/BRIEF.md
# Debug Exception Entry Controller

This block captures the architectural state changes a processor core makes when it takes a debug event. It also holds the core in a special debug state until a status-restore operation ends it. When a debug event is taken, the block does several things. It computes the return link from the event's cause. It saves the current status word and builds a new status word that forces debug mode with interrupts disabled. It picks the redirect vector, which can be low or relocated high. It records the cause code. It raises a set of disable signals aimed at the trace buffer, the instruction MMU and the fetch PID remap.

While the special debug state is active, the block blocks fast and normal interrupt requests whatever the status-word enable bits say. It also drops prefetch aborts. A data abort raises no exception in this state. It only sets a sticky flag. The same state opens the write gate for the breakpoint and debug control registers.

All interfaces are single-cycle strobes or level signals, so there is no valid/ready handshake and no back-pressure. An event strobe is either taken in the cycle it is seen or ignored. The core must hold the PC and status inputs stable in that cycle.

Top module: `dbg_entry_ctrl`

## Requirements
- R1: A taken event with cause 2 (data breakpoint), 4 (external break) or 6 (trace-buffer full) loads `link_out` with `pc_next + 4` on the clock edge where `evt_valid` is sampled.
- R2: A taken event with cause 1 (instruction breakpoint), 3 (software breakpoint) or 5 (vector trap) loads `link_out` with `pc_cur + 4`.
- R3: On a taken event, `saved_status` takes `status_in`. `status_out` takes `status_in[31:8]` with bits [7:0] = 8'hD5, which is mode[4:0] = 5'b10101, bit 5 = 0, bit 6 = 1 and bit 7 = 1.
- R4: On a taken event, `redirect_pc` becomes 32'h0000_0000, or 32'hFFFF_0000 when `vec_high` = 1. `redirect_valid` is high for exactly the one cycle after the taking edge.
- R5: On a taken event, `sds_active` becomes 1, `moe` takes the 3-bit cause code, and `trace_dis` becomes 1.
- R6: While `sds_active` = 1, `fiq_out`, `irq_out` and `pabort_out` are 0. Outside that state, `fiq_out` = `fiq_req & ~status_in[6]`, `irq_out` = `irq_req & ~status_in[7]` and `pabort_out` = `pabort`.
- R7: A `dabort` while `sds_active` = 1 sets `sticky_abort` on the next edge and keeps `dabort_exc` at 0. Outside that state, `dabort_exc` follows `dabort` and `sticky_abort` is untouched.
- R8: `dbgreg_we_ok` is 1 exactly while `sds_active` = 1.
- R9: `immu_dis` and `pid_dis` are 1 while `sds_active` = 1. The state persists when `status_in` changes its mode bits.
- R10: `sds_active` is cleared only by `restore`, one edge after it is sampled. An `evt_valid` seen while `sds_active` = 1 changes neither the link, the status outputs nor `redirect_valid`.
- R11: `sticky_abort` is cleared by `sticky_clr` = 1 only while `sds_active` = 1. A clear request outside that state has no effect. A data abort in the same cycle wins over the clear.
- R12: Causes 0 (reset) and 7 (reserved) are never taken, so `sds_active` stays 0. After reset, every output register is 0, and `moe` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_valid | input | 1 | Debug event strobe |
| evt_cause | input | 3 | Cause code of the event |
| pc_cur | input | 32 | PC of the instruction being aborted |
| pc_next | input | 32 | PC of the next instruction to execute |
| status_in | input | 32 | Current status word |
| vec_high | input | 1 | Vector relocation control |
| dabort | input | 1 | Data abort strobe |
| pabort | input | 1 | Prefetch abort strobe |
| fiq_req | input | 1 | Fast interrupt request |
| irq_req | input | 1 | Normal interrupt request |
| restore | input | 1 | Status-restore strobe |
| sticky_clr | input | 1 | Write-one-to-clear of the sticky abort |
| link_out | output | 32 | Saved debug link value |
| saved_status | output | 32 | Copy of the status at entry |
| status_out | output | 32 | Status word forced at entry |
| redirect_pc | output | 32 | Debug vector address |
| redirect_valid | output | 1 | One-cycle redirect pulse |
| moe | output | 3 | Recorded method of entry |
| sds_active | output | 1 | Special debug state flag |
| fiq_out | output | 1 | Gated fast interrupt |
| irq_out | output | 1 | Gated normal interrupt |
| pabort_out | output | 1 | Gated prefetch abort |
| dabort_exc | output | 1 | Data abort exception request |
| sticky_abort | output | 1 | Sticky data-abort flag |
| trace_dis | output | 1 | Trace buffer disable |
| immu_dis | output | 1 | Instruction MMU disable |
| pid_dis | output | 1 | Fetch PID remap disable |
| dbgreg_we_ok | output | 1 | Debug register write permission |

## Verification
The bench takes every cause with alternating vector selection and a wrapping PC. A design that mixed up the two link sources would return into the wrong instruction. A design that ignored relocation would jump to the wrong vector. Inside the state it sends a second event with new PCs, which a non-reentrant design must not let overwrite the saved link. It also sends data aborts, which must not become exceptions and must set the sticky bit. It then tries a sticky clear outside the state, which must be refused. Causes 0 and 7 are offered as well, and a design that decoded them as valid would wrongly enter the debug state.

// File: rtl/dbg_entry_pkg.sv
package dbg_entry_pkg;

  typedef enum logic [2:0] {
    CAUSE_RST    = 3'd0,
    CAUSE_IBKPT  = 3'd1,
    CAUSE_DBKPT  = 3'd2,
    CAUSE_SWBKPT = 3'd3,
    CAUSE_EXTBRK = 3'd4,
    CAUSE_VTRAP  = 3'd5,
    CAUSE_TBFULL = 3'd6,
    CAUSE_RSVD   = 3'd7
  } cause_e;

  localparam logic [4:0] DBG_MODE_BITS = 5'b10101;
  localparam logic [7:0] DBG_LOW_BYTE  = {1'b1, 1'b1, 1'b0, DBG_MODE_BITS};

  // cause whose return point is the next instruction
  function automatic logic cause_uses_next(input logic [2:0] c);
    return (c == CAUSE_DBKPT) || (c == CAUSE_EXTBRK) || (c == CAUSE_TBFULL);
  endfunction

  // causes that actually open the debug state
  function automatic logic cause_is_taken(input logic [2:0] c);
    return (c != CAUSE_RST) && (c != CAUSE_RSVD);
  endfunction

endpackage

// File: rtl/dbg_link_calc.sv
module dbg_link_calc
  import dbg_entry_pkg::*;
#(
  parameter int          DW      = 32,
  parameter int          CW      = 3,
  parameter logic [31:0] VEC_LO  = 32'h0000_0000,
  parameter logic [31:0] VEC_HI  = 32'hFFFF_0000,
  parameter int          LINK_OFS = 4
) (
  input  logic [CW-1:0] cause,
  input  logic [DW-1:0] pc_cur,
  input  logic [DW-1:0] pc_next,
  input  logic [DW-1:0] status_in,
  input  logic          vec_high,
  output logic [DW-1:0] link_val,
  output logic [DW-1:0] status_new,
  output logic [DW-1:0] vec_pc,
  output logic          taken
);
  localparam logic [DW-1:0] OFS = DW'(LINK_OFS);

  logic [DW-1:0] base_pc;

  always_comb begin
    base_pc    = cause_uses_next(cause) ? pc_next : pc_cur;
    link_val   = base_pc + OFS;
    status_new = {status_in[DW-1:8], DBG_LOW_BYTE};
    vec_pc     = vec_high ? VEC_HI[DW-1:0] : VEC_LO[DW-1:0];
    taken      = cause_is_taken(cause);
  end

endmodule

// File: rtl/dbg_evt_gate.sv
module dbg_evt_gate #(
  parameter int DW = 32,
  parameter int FIQ_EN_BIT = 6,
  parameter int IRQ_EN_BIT = 7
) (
  input  logic          sds,
  input  logic [DW-1:0] status_in,
  input  logic          fiq_req,
  input  logic          irq_req,
  input  logic          pabort,
  input  logic          dabort,
  output logic          fiq_o,
  output logic          irq_o,
  output logic          pabort_o,
  output logic          dabort_exc,
  output logic          trace_dis,
  output logic          immu_dis,
  output logic          pid_dis,
  output logic          dbgreg_we
);
  logic open_path;

  always_comb begin
    open_path  = ~sds;
    fiq_o      = open_path & fiq_req & ~status_in[FIQ_EN_BIT];
    irq_o      = open_path & irq_req & ~status_in[IRQ_EN_BIT];
    pabort_o   = open_path & pabort;
    dabort_exc = open_path & dabort;
    trace_dis  = sds;
    immu_dis   = sds;
    pid_dis    = sds;
    dbgreg_we  = sds;
  end

endmodule

// File: rtl/dbg_sds_state.sv
module dbg_sds_state #(
  parameter int DW = 32,
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          evt_valid,
  input  logic          taken,
  input  logic [CW-1:0] cause,
  input  logic [DW-1:0] link_val,
  input  logic [DW-1:0] status_in,
  input  logic [DW-1:0] status_new,
  input  logic [DW-1:0] vec_pc,
  input  logic          restore,
  input  logic          dabort,
  input  logic          sticky_clr,
  output logic          sds,
  output logic          sticky,
  output logic [DW-1:0] link_q,
  output logic [DW-1:0] saved_q,
  output logic [DW-1:0] status_q,
  output logic [DW-1:0] redirect_q,
  output logic          redirect_v,
  output logic [CW-1:0] moe_q
);
  logic take;
  logic sds_nxt;
  logic sticky_nxt;

  always_comb begin
    take    = evt_valid & taken & ~sds;
    sds_nxt = sds;
    if (sds && restore) sds_nxt = 1'b0;
    else if (take)      sds_nxt = 1'b1;

    sticky_nxt = sticky;
    if (sds && dabort)          sticky_nxt = 1'b1;
    else if (sds && sticky_clr) sticky_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sds        <= 1'b0;
      sticky     <= 1'b0;
      link_q     <= '0;
      saved_q    <= '0;
      status_q   <= '0;
      redirect_q <= '0;
      redirect_v <= 1'b0;
      moe_q      <= '0;
    end else begin
      sds        <= sds_nxt;
      sticky     <= sticky_nxt;
      redirect_v <= take;
      if (take) begin
        link_q     <= link_val;
        saved_q    <= status_in;
        status_q   <= status_new;
        redirect_q <= vec_pc;
        moe_q      <= cause;
      end
    end
  end

  // R5: a taken event opens the state and records its cause
  a_r5_enter: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid && taken && !sds |=> sds && (moe_q == $past(cause)));

  // R10: the state holds until a restore
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    sds && !restore |=> sds);

  a_r10_exit: assert property (@(posedge clk) disable iff (!rst_n)
    sds && restore |=> !sds);

  // R10: an event inside the state is dropped
  a_r10_reentry: assert property (@(posedge clk) disable iff (!rst_n)
    sds && evt_valid |=> $stable(link_q) && $stable(saved_q) && !redirect_v);

  // R4: redirect pulse is a single cycle
  a_r4_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_v |=> !redirect_v);

  // R7: aborts inside the state set the sticky flag
  a_r7_sticky_set: assert property (@(posedge clk) disable iff (!rst_n)
    sds && dabort |=> sticky);

  // R11: no clearing from outside the state
  a_r11_no_clear_out: assert property (@(posedge clk) disable iff (!rst_n)
    !sds && sticky |=> sticky);

  // R12: reset and reserved causes never enter
  a_r12_untaken: assert property (@(posedge clk) disable iff (!rst_n)
    !sds && evt_valid && !taken |=> !sds);

endmodule

// File: rtl/dbg_entry_ctrl.sv
module dbg_entry_ctrl
  import dbg_entry_pkg::*;
#(
  parameter int          DW     = 32,
  parameter int          CW     = 3,
  parameter logic [31:0] VEC_LO = 32'h0000_0000,
  parameter logic [31:0] VEC_HI = 32'hFFFF_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          evt_valid,
  input  logic [CW-1:0] evt_cause,
  input  logic [DW-1:0] pc_cur,
  input  logic [DW-1:0] pc_next,
  input  logic [DW-1:0] status_in,
  input  logic          vec_high,
  input  logic          dabort,
  input  logic          pabort,
  input  logic          fiq_req,
  input  logic          irq_req,
  input  logic          restore,
  input  logic          sticky_clr,
  output logic [DW-1:0] link_out,
  output logic [DW-1:0] saved_status,
  output logic [DW-1:0] status_out,
  output logic [DW-1:0] redirect_pc,
  output logic          redirect_valid,
  output logic [CW-1:0] moe,
  output logic          sds_active,
  output logic          fiq_out,
  output logic          irq_out,
  output logic          pabort_out,
  output logic          dabort_exc,
  output logic          sticky_abort,
  output logic          trace_dis,
  output logic          immu_dis,
  output logic          pid_dis,
  output logic          dbgreg_we_ok
);
  logic [DW-1:0] link_val;
  logic [DW-1:0] status_new;
  logic [DW-1:0] vec_pc;
  logic          taken;

  dbg_link_calc #(.DW(DW), .CW(CW), .VEC_LO(VEC_LO), .VEC_HI(VEC_HI), .LINK_OFS(4)) u_link (
    .cause     (evt_cause),
    .pc_cur    (pc_cur),
    .pc_next   (pc_next),
    .status_in (status_in),
    .vec_high  (vec_high),
    .link_val  (link_val),
    .status_new(status_new),
    .vec_pc    (vec_pc),
    .taken     (taken)
  );

  dbg_sds_state #(.DW(DW), .CW(CW)) u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_valid (evt_valid),
    .taken     (taken),
    .cause     (evt_cause),
    .link_val  (link_val),
    .status_in (status_in),
    .status_new(status_new),
    .vec_pc    (vec_pc),
    .restore   (restore),
    .dabort    (dabort),
    .sticky_clr(sticky_clr),
    .sds       (sds_active),
    .sticky    (sticky_abort),
    .link_q    (link_out),
    .saved_q   (saved_status),
    .status_q  (status_out),
    .redirect_q(redirect_pc),
    .redirect_v(redirect_valid),
    .moe_q     (moe)
  );

  dbg_evt_gate #(.DW(DW)) u_gate (
    .sds       (sds_active),
    .status_in (status_in),
    .fiq_req   (fiq_req),
    .irq_req   (irq_req),
    .pabort    (pabort),
    .dabort    (dabort),
    .fiq_o     (fiq_out),
    .irq_o     (irq_out),
    .pabort_o  (pabort_out),
    .dabort_exc(dabort_exc),
    .trace_dis (trace_dis),
    .immu_dis  (immu_dis),
    .pid_dis   (pid_dis),
    .dbgreg_we (dbgreg_we_ok)
  );

  // R6: nothing escapes the gate while in the debug state
  a_r6_masked: assert property (@(posedge clk) disable iff (!rst_n)
    sds_active |-> !fiq_out && !irq_out && !pabort_out && !dabort_exc);

  // R8 R9: permission and disables track the state
  a_r9_disables: assert property (@(posedge clk) disable iff (!rst_n)
    sds_active |-> immu_dis && pid_dis && trace_dis && dbgreg_we_ok);

  // R3: forced status low byte after an entry
  a_r3_status: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> status_out[7:0] == 8'hD5);

endmodule

// File: tb/sim_dbg_entry_ctrl.sv
`timescale 1ns/1ps
module sim_dbg_entry_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evt_valid = 1'b0;
  logic [2:0]  evt_cause = '0;
  logic [31:0] pc_cur = '0, pc_next = '0, status_in = '0;
  logic        vec_high = 1'b0, dabort = 1'b0, pabort = 1'b0;
  logic        fiq_req = 1'b0, irq_req = 1'b0, restore = 1'b0, sticky_clr = 1'b0;
  logic [31:0] link_out, saved_status, status_out, redirect_pc;
  logic        redirect_valid, sds_active, fiq_out, irq_out, pabort_out, dabort_exc;
  logic        sticky_abort, trace_dis, immu_dis, pid_dis, dbgreg_we_ok;
  logic [2:0]  moe;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dbg_entry_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_cause(evt_cause),
    .pc_cur(pc_cur), .pc_next(pc_next), .status_in(status_in), .vec_high(vec_high),
    .dabort(dabort), .pabort(pabort), .fiq_req(fiq_req), .irq_req(irq_req),
    .restore(restore), .sticky_clr(sticky_clr),
    .link_out(link_out), .saved_status(saved_status), .status_out(status_out),
    .redirect_pc(redirect_pc), .redirect_valid(redirect_valid), .moe(moe),
    .sds_active(sds_active), .fiq_out(fiq_out), .irq_out(irq_out),
    .pabort_out(pabort_out), .dabort_exc(dabort_exc), .sticky_abort(sticky_abort),
    .trace_dis(trace_dis), .immu_dis(immu_dis), .pid_dis(pid_dis),
    .dbgreg_we_ok(dbgreg_we_ok)
  );

  // {cause, vec_high, pc_cur, pc_next, expected link, expected vector}
  localparam logic [131:0] TBL [0:5] = '{
    {3'd1, 1'b0, 32'h0000_1000, 32'h0000_1004, 32'h0000_1004, 32'h0000_0000},
    {3'd2, 1'b1, 32'h0000_2000, 32'h0000_2008, 32'h0000_200C, 32'hFFFF_0000},
    {3'd3, 1'b0, 32'h0000_3000, 32'h0000_3004, 32'h0000_3004, 32'h0000_0000},
    {3'd4, 1'b1, 32'h0000_4000, 32'h0000_4010, 32'h0000_4014, 32'hFFFF_0000},
    {3'd5, 1'b0, 32'h0000_5000, 32'h0000_5004, 32'h0000_5004, 32'h0000_0000},
    {3'd6, 1'b1, 32'hFFFF_FFFC, 32'h0000_0010, 32'h0000_0014, 32'hFFFF_0000}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic fire(input logic [2:0] c, input logic [31:0] cur, input logic [31:0] nxt);
    @(negedge clk);
    evt_cause = c; pc_cur = cur; pc_next = nxt; evt_valid = 1'b1;
    @(negedge clk);
    evt_valid = 1'b0;
  endtask

  task automatic do_restore();
    @(negedge clk);
    restore = 1'b1;
    @(negedge clk);
    restore = 1'b0;
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 reset sds", {31'd0, sds_active}, 32'd0);
    chk("R12 reset link", link_out, 32'd0);
    chk("R12 reset moe", {29'd0, moe}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R6 pass-through outside the state
    status_in = 32'h0000_0013; fiq_req = 1'b1; irq_req = 1'b1; pabort = 1'b1;
    #1;
    chk("R6 fiq open", {31'd0, fiq_out}, 32'd1);
    chk("R6 irq open", {31'd0, irq_out}, 32'd1);
    chk("R6 pabort open", {31'd0, pabort_out}, 32'd1);
    status_in = 32'h0000_0053;
    #1;
    chk("R6 fiq disabled by bit6", {31'd0, fiq_out}, 32'd0);
    chk("R6 irq still open", {31'd0, irq_out}, 32'd1);
    fiq_req = 1'b0; irq_req = 1'b0; pabort = 1'b0;
    chk("R8 no write outside", {31'd0, dbgreg_we_ok}, 32'd0);

    // table of causes: R1 R2 R3 R4 R5
    for (int i = 0; i < 6; i++) begin
      logic [131:0] e;
      logic [31:0]  st;
      e  = TBL[i];
      st = 32'h8000_0010 | 32'(i);
      @(negedge clk);
      status_in = st; vec_high = e[128];
      fire(e[131:129], e[127:96], e[95:64]);
      chk((e[131:129] inside {3'd2, 3'd4, 3'd6}) ? "R1 link" : "R2 link", link_out, e[63:32]);
      chk("R4 vector", redirect_pc, e[31:0]);
      chk("R4 pulse high", {31'd0, redirect_valid}, 32'd1);
      chk("R3 saved", saved_status, st);
      chk("R3 new status", status_out, {st[31:8], 8'hD5});
      chk("R5 moe", {29'd0, moe}, {29'd0, e[131:129]});
      chk("R5 sds", {31'd0, sds_active}, 32'd1);
      chk("R5 trace off", {31'd0, trace_dis}, 32'd1);
      @(negedge clk);
      chk("R4 pulse one cycle", {31'd0, redirect_valid}, 32'd0);
      do_restore();
      chk("R10 exit on restore", {31'd0, sds_active}, 32'd0);
    end

    // R12 untaken causes
    fire(3'd0, 32'h100, 32'h104);
    chk("R12 cause0 no entry", {31'd0, sds_active}, 32'd0);
    chk("R12 cause0 no pulse", {31'd0, redirect_valid}, 32'd0);
    fire(3'd7, 32'h100, 32'h104);
    chk("R12 cause7 no entry", {31'd0, sds_active}, 32'd0);

    // enter and test state behaviour
    vec_high = 1'b0; status_in = 32'h0000_0010;
    fire(3'd1, 32'h0000_0A00, 32'h0000_0A04);
    chk("R2 link", link_out, 32'h0000_0A04);
    @(negedge clk);
    fiq_req = 1'b1; irq_req = 1'b1; pabort = 1'b1; dabort = 1'b1;
    #1;
    chk("R6 fiq masked", {31'd0, fiq_out}, 32'd0);
    chk("R6 irq masked", {31'd0, irq_out}, 32'd0);
    chk("R6 pabort dropped", {31'd0, pabort_out}, 32'd0);
    chk("R7 no exception", {31'd0, dabort_exc}, 32'd0);
    @(negedge clk);
    fiq_req = 1'b0; irq_req = 1'b0; pabort = 1'b0; dabort = 1'b0;
    chk("R7 sticky set", {31'd0, sticky_abort}, 32'd1);
    chk("R8 write allowed", {31'd0, dbgreg_we_ok}, 32'd1);
    // R10 re-entry ignored
    fire(3'd4, 32'h0000_7000, 32'h0000_7004);
    chk("R10 link kept", link_out, 32'h0000_0A04);
    chk("R10 no pulse", {31'd0, redirect_valid}, 32'd0);
    chk("R10 moe kept", {29'd0, moe}, 32'd1);
    // R9 mode change keeps the state
    status_in = 32'h0000_001F;
    repeat (2) @(negedge clk);
    chk("R9 state persists", {31'd0, sds_active}, 32'd1);
    chk("R9 immu off", {31'd0, immu_dis}, 32'd1);
    chk("R9 pid off", {31'd0, pid_dis}, 32'd1);
    // R11 clear inside, abort wins
    sticky_clr = 1'b1; dabort = 1'b1;
    @(negedge clk);
    chk("R11 abort wins clear", {31'd0, sticky_abort}, 32'd1);
    dabort = 1'b0;
    @(negedge clk);
    sticky_clr = 1'b0;
    chk("R11 clear inside", {31'd0, sticky_abort}, 32'd0);
    // set again and exit
    dabort = 1'b1;
    @(negedge clk);
    dabort = 1'b0;
    do_restore();
    chk("R10 exit", {31'd0, sds_active}, 32'd0);
    sticky_clr = 1'b1;
    @(negedge clk);
    sticky_clr = 1'b0;
    chk("R11 clear refused outside", {31'd0, sticky_abort}, 32'd1);
    // R7 abort outside the state
    dabort = 1'b1;
    #1;
    chk("R7 exception outside", {31'd0, dabort_exc}, 32'd1);
    @(negedge clk);
    dabort = 1'b0;
    chk("R7 sticky untouched", {31'd0, sticky_abort}, 32'd1);
    chk("R10 restore outside no entry", {31'd0, sds_active}, 32'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule